// File: doc/BRIEF.md
# Memory Barrier Ordering Gate

This block sits between the load/store issue stage of a processor and a small in-order store queue. It watches an instruction-word stream for the synchronize instruction. When one is accepted, it holds back younger memory requests until the older accesses that the barrier orders against have finished. While the barrier is pending, requests are held by masking the valid signal toward memory and the ready signal toward the issue stage.

A full barrier blocks both request channels. It stays in force until no load is outstanding and the store queue reports empty. A lightweight barrier relaxes one of the four ordering pairs: a younger load may pass stores that are still queued. Younger loads still wait for older loads, and younger stores wait for both older loads and older stores.

The block counts outstanding loads itself, from accepted load requests and load-completion pulses. It exposes a busy flag and a counter of the cycles the current barrier has been pending. It has no architectural register effects.

Top module: `mem_barrier_gate`

## Requirements
- R1: A word is a barrier when bits [31:26] equal 31 and bits [10:1] equal 598. Bit 21 selects the kind: 0 is full (0x7c0004ac) and 1 is lightweight (0x7c2004ac). Any other word is accepted and has no effect: busy stays 0 and both channels pass through.
- R2: `insn_ready` is 0 while a barrier is pending and 1 otherwise. A second barrier therefore waits on its handshake until the first one releases.
- R3: While a full barrier is pending, `ld_out_valid`, `st_out_valid`, `ld_in_ready` and `st_in_ready` are all 0, whatever the channels request.
- R4: A full barrier releases (busy falls) at the clock edge after a cycle in which the outstanding-load count is zero and `sq_empty` is 1.
- R5: Under a lightweight barrier, loads are blocked until the edge after the outstanding-load count is first seen at zero. From then on they pass, even while `sq_empty` is 0.
- R6: Under a lightweight barrier, stores are blocked until the barrier releases. It releases at the edge after a cycle in which the older loads are done and `sq_empty` is 1.
- R7: `stall_cycles` is cleared when a barrier is accepted and rises by one at every edge at which the barrier is pending. It holds its value after the release.
- R8: After reset, `barrier_busy` is 0, `insn_ready` is 1 and `stall_cycles` is 0.
- R9: Every load accepted on the output channel counts as outstanding until a `ld_done` pulse. A barrier waits for loads that were accepted before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| insn_ready | output | 1 | Instruction word accepted |
| ld_in_valid | input | 1 | Load request from issue stage |
| ld_in_ready | output | 1 | Load request taken |
| ld_out_valid | output | 1 | Load request toward memory |
| ld_out_ready | input | 1 | Memory takes load |
| ld_done | input | 1 | One outstanding load completed |
| st_in_valid | input | 1 | Store request from issue stage |
| st_in_ready | output | 1 | Store request taken |
| st_out_valid | output | 1 | Store request toward store queue |
| st_out_ready | input | 1 | Store queue takes store |
| sq_empty | input | 1 | Store queue holds no entry |
| barrier_busy | output | 1 | A barrier is pending |
| stall_cycles | output | 16 | Cycles the current or last barrier was pending |

## Verification
The hardest case is the lightweight barrier's middle phase. Older loads must have drained while the store queue is still occupied, so that loads pass and stores are still held. To reach it, the stimulus issues a load before the barrier and holds `sq_empty` low. It pulses `ld_done` one cycle after the barrier is accepted. It then probes both channels in the cycles just before and just after the load clearance takes effect, and only afterwards lets the queue drain.

// File: rtl/mbg_pkg.sv
package mbg_pkg;
  localparam logic [5:0] PRI_OP = 6'd31;
  localparam logic [9:0] EXT_OP = 10'd598;
  localparam int         KIND_BIT = 21;

  typedef enum logic {
    BAR_FULL  = 1'b0,
    BAR_LIGHT = 1'b1
  } bar_kind_e;
endpackage

// File: rtl/mbg_decode.sv
module mbg_decode
  import mbg_pkg::*;
(
  input  logic [31:0] word,
  output logic        is_barrier,
  output bar_kind_e   kind
);
  always_comb begin
    is_barrier = (word[31:26] == PRI_OP) && (word[10:1] == EXT_OP);
    kind       = word[KIND_BIT] ? BAR_LIGHT : BAR_FULL;
  end
endmodule

// File: rtl/mbg_ld_tracker.sv
module mbg_ld_tracker #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic retire,
  output logic zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (issue && !retire) cnt_q <= cnt_q + 1'b1;
    else if (retire && !issue) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_LD_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (retire && !issue) |-> (cnt_q != '0)); // R9
endmodule

// File: rtl/mbg_ctrl.sv
module mbg_ctrl
  import mbg_pkg::*;
#(
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  bar_kind_e          kind,
  input  logic               ld_zero,
  input  logic               sq_empty,
  output logic               busy,
  output logic               ld_block,
  output logic               st_block,
  output logic [STALL_W-1:0] stall_cycles
);
  localparam logic [STALL_W-1:0] STALL_MAX = '1;

  logic               busy_q;
  bar_kind_e          kind_q;
  logic               ld_clear_q;
  logic [STALL_W-1:0] stall_q;
  logic               loads_ok;
  logic               release_now;

  always_comb begin
    loads_ok    = (kind_q == BAR_LIGHT) ? (ld_clear_q || ld_zero) : ld_zero;
    release_now = busy_q && loads_ok && sq_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      kind_q     <= BAR_FULL;
      ld_clear_q <= 1'b0;
      stall_q    <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      kind_q     <= kind;
      ld_clear_q <= 1'b0;
      stall_q    <= '0;
    end else if (busy_q) begin
      if (stall_q != STALL_MAX) stall_q <= stall_q + 1'b1;
      if (ld_zero) ld_clear_q <= 1'b1;
      if (release_now) busy_q <= 1'b0;
    end
  end

  assign busy         = busy_q;
  assign ld_block     = busy_q && !((kind_q == BAR_LIGHT) && ld_clear_q);
  assign st_block     = busy_q;
  assign stall_cycles = stall_q;

  AST_STALL_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && stall_q != STALL_MAX) |=> (stall_q == $past(stall_q) + 1'b1)); // R7
  AST_LIGHT_LD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !ld_zero && !ld_clear_q) |-> ld_block); // R5
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !accept); // R2
endmodule

// File: rtl/mem_barrier_gate.sv
module mem_barrier_gate
  import mbg_pkg::*;
#(
  parameter int LD_CNT_W = 4,
  parameter int STALL_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_valid,
  input  logic [31:0]        insn_word,
  output logic               insn_ready,
  input  logic               ld_in_valid,
  output logic               ld_in_ready,
  output logic               ld_out_valid,
  input  logic               ld_out_ready,
  input  logic               ld_done,
  input  logic               st_in_valid,
  output logic               st_in_ready,
  output logic               st_out_valid,
  input  logic               st_out_ready,
  input  logic               sq_empty,
  output logic               barrier_busy,
  output logic [STALL_W-1:0] stall_cycles
);
  logic      is_barrier;
  bar_kind_e kind;
  logic      accept;
  logic      ld_zero;
  logic      ld_block;
  logic      st_block;
  logic      busy;

  mbg_decode u_decode (
    .word       (insn_word),
    .is_barrier (is_barrier),
    .kind       (kind)
  );

  assign insn_ready = !busy;
  assign accept     = insn_valid && insn_ready && is_barrier;

  assign ld_out_valid = ld_in_valid && !ld_block;
  assign ld_in_ready  = ld_out_ready && !ld_block;
  assign st_out_valid = st_in_valid && !st_block;
  assign st_in_ready  = st_out_ready && !st_block;

  mbg_ld_tracker #(.CNT_W(LD_CNT_W)) u_ld_tracker (
    .clk    (clk),
    .rst    (rst),
    .issue  (ld_out_valid && ld_out_ready),
    .retire (ld_done),
    .zero   (ld_zero)
  );

  mbg_ctrl #(.STALL_W(STALL_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .kind         (kind),
    .ld_zero      (ld_zero),
    .sq_empty     (sq_empty),
    .busy         (busy),
    .ld_block     (ld_block),
    .st_block     (st_block),
    .stall_cycles (stall_cycles)
  );

  assign barrier_busy = busy;

  AST_INSN_HELD: assert property (@(posedge clk) disable iff (rst)
    barrier_busy |-> !insn_ready); // R2
  AST_ST_HELD: assert property (@(posedge clk) disable iff (rst)
    barrier_busy |-> (!st_out_valid && !st_in_ready)); // R6
  AST_RELEASE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    $fell(barrier_busy) |-> $past(sq_empty)); // R4
endmodule

// File: tb/mem_barrier_gate_tb_top.sv
module mem_barrier_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = 32'h0;
  logic        insn_ready;
  logic        ld_in_valid = 1'b0;
  logic        ld_in_ready;
  logic        ld_out_valid;
  logic        ld_out_ready = 1'b1;
  logic        ld_done = 1'b0;
  logic        st_in_valid = 1'b0;
  logic        st_in_ready;
  logic        st_out_valid;
  logic        st_out_ready = 1'b1;
  logic        sq_empty = 1'b1;
  logic        barrier_busy;
  logic [15:0] stall_cycles;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  localparam logic [31:0] W_FULL  = 32'h7c0004ac;
  localparam logic [31:0] W_LIGHT = 32'h7c2004ac;

  always #10 clk = ~clk;

  mem_barrier_gate dut_i (
    .clk(clk), .rst(rst),
    .insn_valid(insn_valid), .insn_word(insn_word), .insn_ready(insn_ready),
    .ld_in_valid(ld_in_valid), .ld_in_ready(ld_in_ready),
    .ld_out_valid(ld_out_valid), .ld_out_ready(ld_out_ready), .ld_done(ld_done),
    .st_in_valid(st_in_valid), .st_in_ready(st_in_ready),
    .st_out_valid(st_out_valid), .st_out_ready(st_out_ready),
    .sq_empty(sq_empty), .barrier_busy(barrier_busy), .stall_cycles(stall_cycles)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offer both requests for a moment without letting any handshake complete.
  task automatic probe(output logic lo, output logic li, output logic so, output logic si);
    ld_in_valid = 1'b1;
    st_in_valid = 1'b1;
    #1;
    lo = ld_out_valid; li = ld_in_ready; so = st_out_valid; si = st_in_ready;
    ld_in_valid = 1'b0;
    st_in_valid = 1'b0;
    #1;
  endtask

  // Offer a word at a negedge; accepted at the next edge when ready.
  task automatic send_word(input logic [31:0] w);
    insn_word  = w;
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic issue_load();
    ld_in_valid = 1'b1;
    @(negedge clk);
    ld_in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R8", "busy after reset", barrier_busy, 0);
    check("R8", "insn_ready after reset", insn_ready, 1);
    check("R8", "stall after reset", stall_cycles, 0);
  endtask

  task automatic t_non_barrier();
    logic lo, li, so, si;
    send_word(32'h7c0006ac);
    check("R1", "busy after other extended op", barrier_busy, 0);
    send_word(32'h4c00012c);
    check("R1", "busy after other primary op", barrier_busy, 0);
    probe(lo, li, so, si);
    check("R1", "ld passes after non-barrier", lo, 1);
    check("R1", "st passes after non-barrier", so, 1);
  endtask

  task automatic t_full_quick();
    logic lo, li, so, si;
    sq_empty = 1'b1;
    send_word(W_FULL);
    check("R3", "busy after full accept", barrier_busy, 1);
    probe(lo, li, so, si);
    check("R3", "full blocks ld_out_valid", lo, 0);
    check("R3", "full blocks ld_in_ready", li, 0);
    check("R3", "full blocks st_out_valid", so, 0);
    check("R3", "full blocks st_in_ready", si, 0);
    @(negedge clk);
    check("R4", "full releases when drained", barrier_busy, 0);
    check("R7", "stall of immediate release", stall_cycles, 1);
  endtask

  task automatic t_full_drain(input int n);
    sq_empty = 1'b0;
    send_word(W_FULL);
    // second barrier offered while the first is pending
    insn_word  = W_LIGHT;
    insn_valid = 1'b1;
    #1;
    check("R2", "insn_ready low while pending", insn_ready, 0);
    repeat (n) @(negedge clk);
    check("R4", "still busy while queue occupied", barrier_busy, 1);
    insn_valid = 1'b0;
    sq_empty = 1'b1;
    @(negedge clk);
    check("R4", "released one edge after drain", barrier_busy, 0);
    check("R7", "stall equals drain time", stall_cycles, n + 1);
    @(negedge clk);
    check("R2", "held second barrier not taken", barrier_busy, 0);
    check("R7", "stall holds after release", stall_cycles, n + 1);
  endtask

  task automatic t_full_load(input int n);
    sq_empty = 1'b1;
    issue_load();
    send_word(W_FULL);
    repeat (n) @(negedge clk);
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
    check("R9", "busy until older load completes", barrier_busy, 1);
    @(negedge clk);
    check("R9", "released after load completion", barrier_busy, 0);
    check("R9", "stall covers load wait", stall_cycles, n + 2);
  endtask

  task automatic t_light_split();
    logic lo, li, so, si;
    sq_empty = 1'b0;
    issue_load();
    send_word(W_LIGHT);
    probe(lo, li, so, si);
    check("R5", "light blocks load behind older load", lo, 0);
    check("R6", "light blocks store", so, 0);
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
    probe(lo, li, so, si);
    check("R5", "load still blocked before clearance edge", li, 0);
    @(negedge clk);
    probe(lo, li, so, si);
    check("R5", "load passes while stores queued", lo, 1);
    check("R5", "load ready while stores queued", li, 1);
    check("R6", "store held while queue occupied", so, 0);
    check("R6", "busy while queue occupied", barrier_busy, 1);
    sq_empty = 1'b1;
    @(negedge clk);
    check("R6", "light released after drain", barrier_busy, 0);
    check("R7", "light stall count", stall_cycles, 3);
    probe(lo, li, so, si);
    check("R6", "store passes after release", so, 1);
  endtask

  task automatic t_light_quick();
    sq_empty = 1'b1;
    send_word(W_LIGHT);
    check("R1", "light word sets busy", barrier_busy, 1);
    @(negedge clk);
    check("R6", "light releases at once when idle", barrier_busy, 0);
    check("R7", "light stall immediate", stall_cycles, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_non_barrier();
    t_full_quick();
    t_full_drain(5);
    t_full_load(2);
    t_light_split();
    t_light_quick();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule